// File: doc/BRIEF.md
# Multithreaded Decode Skid Controller

This block sits between instruction fetch and the rename stage of a superscalar core that runs a small fixed number of hardware threads. Each cycle it receives a bundle of opaque instructions, each tagged with its thread, and splits the bundle by thread. It then fills a shared set of output slots, serving threads in index order. Each thread runs its own five-state machine: Idle, Running, Blocked, Unblocking and Squashing.

Three downstream sources send per-thread stall set and clear pulses. When a thread cannot move forward, its pending instructions are parked in a private skid buffer, and fetch gets a one-cycle block pulse. Once the stall is gone, the thread empties its skid buffer before it takes fresh input again. When the buffer is empty, fetch gets an unblock pulse. A squash request from commit empties the thread's buffers and throws away its incoming instructions.

All outputs are registered, so the results of a cycle's inputs appear one clock later.

Top module: `dss_skid_ctrl`

## Requirements
- R1: After reset every thread is Idle with empty skid buffer and no stall flags; all outputs are 0.
- R2: Each thread has three sticky stall flags, one per source (set/clear input bit index = thread*3 + source). A set pulse sets a flag, a clear pulse clears it, and clear wins when both arrive in the same cycle. The thread is stalled while any flag is set after this cycle's pulses.
- R3: Per thread each cycle the first matching case wins, in this order: squash request; commit still squashing (state Squashing, incoming dropped, skid kept); stalled (go Blocked); Blocked goes to Unblocking; Squashing goes to Running.
- R4: A stalled thread appends all its incoming instructions to its skid buffer. A block pulse goes out only on the cycle the thread enters Blocked, never while it stays Blocked.
- R5: In Unblocking the thread first drains its skid buffer into free slots, then appends that cycle's incoming instructions. When the buffer ends the cycle empty, the thread goes to Running and sends an unblock pulse. A Blocked thread whose buffer is already empty goes straight to Running with an unblock pulse.
- R6: At most DECODE_WIDTH instructions leave per cycle. Thread 0 is served first and slots fill from slot 0 with no gaps. Each thread's instructions keep their arrival order, with lower bundle positions first.
- R7: An instruction marked killed that is reached while a slot is still free is dropped and uses no slot.
- R8: If a Running or Idle thread has instructions left after the slots are used up, the rest go to its skid buffer and the thread becomes Blocked with a block pulse.
- R9: Skid depth is FETCH_DELAY*FETCH_WIDTH + DECODE_WIDTH entries. A full buffer of that size drains with nothing lost.
- R10: A squash request flushes the thread's skid buffer and drops its incoming instructions, so none of them leave the next cycle. If the thread was Blocked or Unblocking, an unblock pulse is sent.
- R11: The issue-ready bit of an output slot equals the instruction's no-source-operand flag.
- R12: stage_active is 1 exactly when at least one thread ended the previous cycle in Unblocking.
- R13: A clear pulse to a flag that is not set (even after this cycle's set) raises proto_err, which stays 1 until reset.
- R14: If a thread would send unblock and block in the same cycle (going straight from Blocked to Running and then running out of slots), both pulses are withheld and the thread stays Blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_valid | input | FETCH_WIDTH | Bundle position holds an instruction |
| fe_tid | input | FETCH_WIDTH*TID_W | Thread tag per position |
| fe_payload | input | FETCH_WIDTH*PAYLOAD_W | Opaque instruction payload per position |
| fe_killed | input | FETCH_WIDTH | Instruction already marked squashed |
| fe_nosrc | input | FETCH_WIDTH | Instruction reads no source register |
| stall_set | input | NUM_THREADS*3 | Block pulses, index thread*3+source |
| stall_clr | input | NUM_THREADS*3 | Unblock pulses, index thread*3+source |
| cm_squash | input | NUM_THREADS | Squash request per thread |
| cm_squashing | input | NUM_THREADS | Commit still squashing per thread |
| dq_valid | output | DECODE_WIDTH | Output slot holds an instruction |
| dq_tid | output | DECODE_WIDTH*TID_W | Thread tag per slot |
| dq_payload | output | DECODE_WIDTH*PAYLOAD_W | Payload per slot |
| dq_issue_ok | output | DECODE_WIDTH | Instruction may issue without operands |
| fe_block | output | NUM_THREADS | One-cycle block pulse to fetch |
| fe_unblock | output | NUM_THREADS | One-cycle unblock pulse to fetch |
| stage_active | output | 1 | Some thread is Unblocking |
| proto_err | output | 1 | Sticky misuse of a clear pulse |

## Verification
The hardest case to reach is R14. It needs a thread that sits Blocked with an empty skid buffer, sees its stall cleared, and in that same cycle gets more instructions than the slots a lower thread left free. The stimulus gets there by running long phases with heavy fetch traffic, short random stalls and frequent stall clears on both threads, so the lower-index thread often takes the shared slots. Filling the skid buffer to exactly its depth (R9) comes from letting fetch send to a thread whenever the bench's model says there is room. A behavioural model with queues predicts every output on every clock.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef enum logic [2:0] {
        TS_IDLE    = 3'd0,
        TS_RUN     = 3'd1,
        TS_BLOCKED = 3'd2,
        TS_UNBLOCK = 3'd3,
        TS_SQUASH  = 3'd4
    } thr_state_e;

    localparam int unsigned NUM_SRC   = 3;
    localparam int unsigned ENT_NOSRC = 0;
    localparam int unsigned ENT_KILL  = 1;

endpackage

// File: rtl/dss_stall_track.sv
module dss_stall_track #(
    parameter int unsigned NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic            stalled_o,
    output logic            misuse_o
);
    logic [NSRC-1:0] flags_d, flags_q;

    always_comb begin
        flags_d   = (flags_q | set_i) & ~clr_i;
        stalled_o = |flags_d;
        misuse_o  = |(clr_i & ~(flags_q | set_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/dss_fetch_sort.sv
module dss_fetch_sort #(
    parameter int unsigned NT     = 2,
    parameter int unsigned FW     = 2,
    parameter int unsigned TW     = 1,
    parameter int unsigned EW     = 10,
    parameter int unsigned FCW    = 2
) (
    input  logic [FW-1:0]                 in_valid,
    input  logic [FW-1:0][TW-1:0]         in_tid,
    input  logic [FW-1:0][EW-1:0]         in_ent,
    output logic [NT-1:0][FW-1:0][EW-1:0] out_ent,
    output logic [NT-1:0][FCW-1:0]        out_cnt
);
    always_comb begin
        int rank;
        out_ent = '0;
        out_cnt = '0;
        for (int t = 0; t < NT; t++) begin
            rank = 0;
            for (int i = 0; i < FW; i++) begin
                if (in_valid[i] && (in_tid[i] == TW'(t))) begin
                    for (int j = 0; j < FW; j++) begin
                        if (j == rank) out_ent[t][j] = in_ent[i];
                    end
                    rank = rank + 1;
                end
            end
            out_cnt[t] = FCW'(rank);
        end
    end
endmodule

// File: rtl/dss_skid_ctrl.sv
module dss_skid_ctrl #(
    parameter int unsigned NUM_THREADS  = 2,
    parameter int unsigned FETCH_WIDTH  = 2,
    parameter int unsigned DECODE_WIDTH = 2,
    parameter int unsigned FETCH_DELAY  = 1,
    parameter int unsigned PAYLOAD_W    = 8,
    localparam int unsigned TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [FETCH_WIDTH-1:0]            fe_valid,
    input  logic [FETCH_WIDTH*TID_W-1:0]      fe_tid,
    input  logic [FETCH_WIDTH*PAYLOAD_W-1:0]  fe_payload,
    input  logic [FETCH_WIDTH-1:0]            fe_killed,
    input  logic [FETCH_WIDTH-1:0]            fe_nosrc,
    input  logic [NUM_THREADS*3-1:0]          stall_set,
    input  logic [NUM_THREADS*3-1:0]          stall_clr,
    input  logic [NUM_THREADS-1:0]            cm_squash,
    input  logic [NUM_THREADS-1:0]            cm_squashing,
    output logic [DECODE_WIDTH-1:0]           dq_valid,
    output logic [DECODE_WIDTH*TID_W-1:0]     dq_tid,
    output logic [DECODE_WIDTH*PAYLOAD_W-1:0] dq_payload,
    output logic [DECODE_WIDTH-1:0]           dq_issue_ok,
    output logic [NUM_THREADS-1:0]            fe_block,
    output logic [NUM_THREADS-1:0]            fe_unblock,
    output logic                              stage_active,
    output logic                              proto_err
);
    import dss_pkg::*;

    localparam int unsigned NT         = NUM_THREADS;
    localparam int unsigned FW         = FETCH_WIDTH;
    localparam int unsigned DW         = DECODE_WIDTH;
    localparam int unsigned NSRC       = NUM_SRC;
    localparam int unsigned SKID_DEPTH = FETCH_DELAY * FETCH_WIDTH + DECODE_WIDTH;
    localparam int unsigned CNT_W      = $clog2(SKID_DEPTH + 1);
    localparam int unsigned FCNT_W     = $clog2(FW + 1);
    localparam int unsigned ENT_W      = PAYLOAD_W + 2;

    typedef logic [SKID_DEPTH-1:0][ENT_W-1:0] skid_t;
    typedef logic [FW-1:0][ENT_W-1:0]         bundle_t;

    typedef struct packed {
        logic [NT-1:0][2:0]           st;
        logic [NT-1:0][SKID_DEPTH-1:0][ENT_W-1:0] skid;
        logic [NT-1:0][CNT_W-1:0]     cnt;
        logic [DW-1:0]                dq_valid;
        logic [DW-1:0][TID_W-1:0]     dq_tid;
        logic [DW-1:0][PAYLOAD_W-1:0] dq_pay;
        logic [DW-1:0]                dq_ok;
        logic [NT-1:0]                blk;
        logic [NT-1:0]                unb;
        logic                         active;
        logic                         err;
    } regs_t;

    regs_t r_d, r_q;

    logic [FW-1:0][TID_W-1:0]         tid_a;
    logic [FW-1:0][ENT_W-1:0]         ent_a;
    logic [NT-1:0][FW-1:0][ENT_W-1:0] srt_ent;
    logic [NT-1:0][FCNT_W-1:0]        srt_cnt;
    logic [NT-1:0]                    stalled;
    logic [NT-1:0]                    misuse;
    logic                             skid_over;

    assign tid_a = fe_tid;

    always_comb begin
        for (int i = 0; i < FW; i++) begin
            ent_a[i] = {fe_payload[i*PAYLOAD_W +: PAYLOAD_W], fe_killed[i], fe_nosrc[i]};
        end
    end

    dss_fetch_sort #(
        .NT(NT), .FW(FW), .TW(TID_W), .EW(ENT_W), .FCW(FCNT_W)
    ) u_sort (
        .in_valid(fe_valid),
        .in_tid  (tid_a),
        .in_ent  (ent_a),
        .out_ent (srt_ent),
        .out_cnt (srt_cnt)
    );

    for (genvar g = 0; g < NT; g++) begin : g_trk
        dss_stall_track #(.NSRC(NSRC)) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (stall_set[g*NSRC +: NSRC]),
            .clr_i    (stall_clr[g*NSRC +: NSRC]),
            .stalled_o(stalled[g]),
            .misuse_o (misuse[g])
        );
    end

    // Append bundle entries [from, cnt) behind the current occupancy.
    function automatic void skid_push(inout skid_t w, inout int sc, inout logic over,
                                      input bundle_t lst, input int from, input int cnt);
        for (int k = 0; k < FW; k++) begin
            if (k >= from && k < cnt) begin
                if (sc + k - from >= SKID_DEPTH) over = 1'b1;
                for (int j = 0; j < SKID_DEPTH; j++) begin
                    if (j == sc + k - from) w[j] = lst[k];
                end
            end
        end
        if (cnt > from) sc = sc + cnt - from;
        if (sc > SKID_DEPTH) sc = SKID_DEPTH;
    endfunction

    // Place one surviving instruction into the next free output slot.
    function automatic void slot_emit(inout regs_t r, inout int slots,
                                      input logic [ENT_W-1:0] e, input int t);
        if (!e[ENT_KILL]) begin
            for (int s = 0; s < DW; s++) begin
                if (s == slots) begin
                    r.dq_valid[s] = 1'b1;
                    r.dq_tid[s]   = TID_W'(t);
                    r.dq_pay[s]   = e[ENT_W-1:2];
                    r.dq_ok[s]    = e[ENT_NOSRC];
                end
            end
            slots = slots + 1;
        end
    endfunction

    always_comb begin
        int         slots, sc, nin, take;
        logic       over;
        thr_state_e st;
        skid_t      w, wn;

        r_d          = r_q;
        r_d.dq_valid = '0;
        r_d.dq_tid   = '0;
        r_d.dq_pay   = '0;
        r_d.dq_ok    = '0;
        r_d.blk      = '0;
        r_d.unb      = '0;
        slots        = 0;
        over         = 1'b0;

        for (int t = 0; t < NT; t++) begin
            st   = thr_state_e'(r_q.st[t]);
            sc   = int'(r_q.cnt[t]);
            w    = r_q.skid[t];
            nin  = int'(srt_cnt[t]);
            take = 0;
            wn   = '0;
            if (cm_squash[t]) begin
                if (st == TS_BLOCKED || st == TS_UNBLOCK) r_d.unb[t] = 1'b1;
                st = TS_SQUASH;
                sc = 0;
                w  = '0;
            end else if (cm_squashing[t]) begin
                st = TS_SQUASH;
            end else if (stalled[t]) begin
                skid_push(w, sc, over, srt_ent[t], 0, nin);
                if (st != TS_BLOCKED) begin
                    st         = TS_BLOCKED;
                    r_d.blk[t] = 1'b1;
                end
            end else begin
                if (st == TS_BLOCKED) begin
                    st = TS_UNBLOCK;
                    if (sc == 0) begin
                        st         = TS_RUN;
                        r_d.unb[t] = 1'b1;
                    end
                end else if (st == TS_SQUASH) begin
                    st = TS_RUN;
                end
                if (st == TS_UNBLOCK) begin
                    for (int k = 0; k < SKID_DEPTH; k++) begin
                        if (k < sc && slots < DW) begin
                            take = k + 1;
                            slot_emit(r_d, slots, w[k], t);
                        end
                    end
                    for (int j = 0; j < SKID_DEPTH; j++) begin
                        for (int k = 0; k < SKID_DEPTH; k++) begin
                            if (k == j + take) wn[j] = w[k];
                        end
                    end
                    w  = wn;
                    sc = sc - take;
                    skid_push(w, sc, over, srt_ent[t], 0, nin);
                    if (sc == 0) begin
                        st         = TS_RUN;
                        r_d.unb[t] = 1'b1;
                    end
                end else begin
                    for (int k = 0; k < FW; k++) begin
                        if (k < nin && slots < DW) begin
                            take = k + 1;
                            slot_emit(r_d, slots, srt_ent[t][k], t);
                        end
                    end
                    if (take < nin) begin
                        skid_push(w, sc, over, srt_ent[t], take, nin);
                        st = TS_BLOCKED;
                        if (r_d.unb[t]) r_d.unb[t] = 1'b0;
                        else            r_d.blk[t] = 1'b1;
                    end
                end
            end
            r_d.st[t]   = st;
            r_d.skid[t] = w;
            r_d.cnt[t]  = CNT_W'(sc);
        end

        r_d.active = 1'b0;
        for (int t = 0; t < NT; t++) begin
            if (thr_state_e'(r_d.st[t]) == TS_UNBLOCK) r_d.active = 1'b1;
        end
        r_d.err   = r_q.err | (|misuse);
        skid_over = over;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dq_valid     = r_q.dq_valid;
    assign dq_tid       = r_q.dq_tid;
    assign dq_payload   = r_q.dq_pay;
    assign dq_issue_ok  = r_q.dq_ok;
    assign fe_block     = r_q.blk;
    assign fe_unblock   = r_q.unb;
    assign stage_active = r_q.active;
    assign proto_err    = r_q.err;

    AST_NO_SKID_LOSS: assert property (@(posedge clk) disable iff (!rst_n) !skid_over); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) proto_err |=> proto_err); // R13

    for (genvar g = 0; g < NT; g++) begin : g_thr_ast
        AST_BLOCK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            fe_block[g] |=> !fe_block[g]); // R4
        AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            !(fe_block[g] && fe_unblock[g])); // R14
        for (genvar s = 0; s < DW; s++) begin : g_slot
            AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                cm_squash[g] |=> !(dq_valid[s] && (dq_tid[s*TID_W +: TID_W] == TID_W'(g)))); // R10
        end
    end

    for (genvar s = 0; s + 1 < DW; s++) begin : g_pack_ast
        AST_SLOT_PACK: assert property (@(posedge clk) disable iff (!rst_n)
            dq_valid[s+1] |-> dq_valid[s]); // R6
    end
endmodule

// File: tb/dss_skid_ctrl_test.sv
`timescale 1ns/1ps
module dss_skid_ctrl_test;
    localparam int NT = 2, FW = 2, DW = 2, FD = 1, PW = 8, TW = 1;
    localparam int DEPTH = FD * FW + DW;

    typedef struct packed {
        logic [PW-1:0] pay;
        logic          tid;
        logic          kill;
        logic          nos;
    } ent_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [FW-1:0] fe_valid, fe_killed, fe_nosrc;
    logic [FW*TW-1:0] fe_tid;
    logic [FW*PW-1:0] fe_payload;
    logic [NT*3-1:0] st_set, st_clr;
    logic [NT-1:0] cm_squash, cm_squashing;
    logic [DW-1:0] dq_valid, dq_issue_ok;
    logic [DW*TW-1:0] dq_tid;
    logic [DW*PW-1:0] dq_payload;
    logic [NT-1:0] fe_block, fe_unblock;
    logic stage_active, proto_err;

    always #5 clk = ~clk;

    dss_skid_ctrl #(.NUM_THREADS(NT), .FETCH_WIDTH(FW), .DECODE_WIDTH(DW),
                    .FETCH_DELAY(FD), .PAYLOAD_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_tid(fe_tid),
        .fe_payload(fe_payload), .fe_killed(fe_killed), .fe_nosrc(fe_nosrc),
        .stall_set(st_set), .stall_clr(st_clr), .cm_squash(cm_squash),
        .cm_squashing(cm_squashing), .dq_valid(dq_valid), .dq_tid(dq_tid),
        .dq_payload(dq_payload), .dq_issue_ok(dq_issue_ok), .fe_block(fe_block),
        .fe_unblock(fe_unblock), .stage_active(stage_active), .proto_err(proto_err));

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model: 0 idle, 1 run, 2 blocked, 3 unblocking, 4 squashing
    int   m_st [NT];
    bit   m_flag [NT][3];
    bit   m_err;
    ent_t skq [NT][$];
    logic [DW-1:0] e_valid, e_ok;
    logic [DW*TW-1:0] e_tid;
    logic [DW*PW-1:0] e_pay;
    logic [NT-1:0] e_blk, e_unb;
    logic e_act;

    task automatic chk(string tag, logic [63:0] a, logic [63:0] x);
        checks++;
        if (a !== x) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, a, x);
        end
    endtask

    task automatic emit(ent_t e, ref int slots);
        if (!e.kill) begin
            e_valid[slots] = 1'b1;
            e_tid[slots] = e.tid;
            e_pay[slots*PW +: PW] = e.pay;
            e_ok[slots] = e.nos;
            slots++;
        end
    endtask

    task automatic model_step();
        ent_t inq[$];
        ent_t e;
        int slots, i;
        bit mid, stl;
        e_valid = '0; e_ok = '0; e_tid = '0; e_pay = '0; e_blk = '0; e_unb = '0;
        slots = 0;
        for (int t = 0; t < NT; t++) begin
            stl = 0;
            for (int s = 0; s < 3; s++) begin
                mid = m_flag[t][s] | st_set[t*3+s];
                if (st_clr[t*3+s] && !mid) m_err = 1;
                m_flag[t][s] = mid & !st_clr[t*3+s];
                stl |= m_flag[t][s];
            end
            inq.delete();
            for (int k = 0; k < FW; k++) begin
                if (fe_valid[k] && int'(fe_tid[k]) == t) begin
                    e.pay = fe_payload[k*PW +: PW]; e.tid = fe_tid[k];
                    e.kill = fe_killed[k]; e.nos = fe_nosrc[k];
                    inq.push_back(e);
                end
            end
            if (cm_squash[t]) begin
                if (m_st[t] == 2 || m_st[t] == 3) e_unb[t] = 1;
                m_st[t] = 4;
                skq[t].delete();
            end else if (cm_squashing[t]) begin
                m_st[t] = 4;
            end else if (stl) begin
                foreach (inq[k]) skq[t].push_back(inq[k]);
                if (m_st[t] != 2) begin m_st[t] = 2; e_blk[t] = 1; end
            end else begin
                if (m_st[t] == 2) begin
                    m_st[t] = 3;
                    if (skq[t].size() == 0) begin m_st[t] = 1; e_unb[t] = 1; end
                end else if (m_st[t] == 4) m_st[t] = 1;
                if (m_st[t] == 3) begin
                    while (skq[t].size() > 0 && slots < DW) begin
                        e = skq[t].pop_front();
                        emit(e, slots);
                    end
                    foreach (inq[k]) skq[t].push_back(inq[k]);
                    if (skq[t].size() == 0) begin m_st[t] = 1; e_unb[t] = 1; end
                end else begin
                    i = 0;
                    while (i < inq.size() && slots < DW) begin
                        emit(inq[i], slots);
                        i++;
                    end
                    if (i < inq.size()) begin
                        for (int k = i; k < inq.size(); k++) skq[t].push_back(inq[k]);
                        m_st[t] = 2;
                        if (e_unb[t]) e_unb[t] = 0; else e_blk[t] = 1;
                    end
                end
            end
        end
        e_act = 0;
        for (int t = 0; t < NT; t++) if (m_st[t] == 3) e_act = 1;
    endtask

    task automatic compare();
        chk("R3 R6 R7 R8 R9 dq_valid", 64'(dq_valid), 64'(e_valid));
        chk("R6 dq_tid", 64'(dq_tid), 64'(e_tid));
        chk("R5 R6 R9 dq_payload", 64'(dq_payload), 64'(e_pay));
        chk("R11 dq_issue_ok", 64'(dq_issue_ok), 64'(e_ok));
        chk("R2 R3 R4 R8 R14 fe_block", 64'(fe_block), 64'(e_blk));
        chk("R5 R10 R14 fe_unblock", 64'(fe_unblock), 64'(e_unb));
        chk("R12 stage_active", 64'(stage_active), 64'(e_act));
        chk("R13 proto_err", 64'(proto_err), 64'(m_err));
    endtask

    task automatic drive_idle();
        fe_valid = '0; fe_tid = '0; fe_payload = '0; fe_killed = '0; fe_nosrc = '0;
        st_set = '0; st_clr = '0; cm_squash = '0; cm_squashing = '0;
    endtask

    task automatic gen(int pf, int pst, int pclr, int psq, bit wild);
        int cnt [NT];
        int t;
        drive_idle();
        for (int k = 0; k < NT; k++) cnt[k] = 0;
        for (int k = 0; k < FW; k++) begin
            if ($urandom_range(99) < pf) begin
                t = $urandom_range(NT-1);
                if (skq[t].size() + cnt[t] + 1 <= DEPTH) begin
                    cnt[t]++;
                    fe_valid[k] = 1'b1;
                    fe_tid[k] = t[0];
                    fe_payload[k*PW +: PW] = PW'($urandom);
                    fe_killed[k] = ($urandom_range(4) == 0);
                    fe_nosrc[k] = ($urandom_range(2) == 0);
                end
            end
        end
        for (int i = 0; i < NT*3; i++) begin
            st_set[i] = ($urandom_range(99) < pst);
            if (wild) st_clr[i] = ($urandom_range(99) < pst);
            else st_clr[i] = (m_flag[i/3][i%3] | st_set[i]) && ($urandom_range(99) < pclr);
        end
        for (int k = 0; k < NT; k++) begin
            cm_squash[k] = ($urandom_range(99) < psq);
            cm_squashing[k] = ($urandom_range(99) < psq);
        end
    endtask

    task automatic run(int n, int pf, int pst, int pclr, int psq, bit wild);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            compare();
            gen(pf, pst, pclr, psq, wild);
            model_step();
        end
    endtask

    initial begin
        drive_idle();
        m_err = 0;
        for (int t = 0; t < NT; t++) begin
            m_st[t] = 0;
            for (int s = 0; s < 3; s++) m_flag[t][s] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        chk("R1 dq_valid", 64'(dq_valid), 64'h0);
        chk("R1 fe_block", 64'(fe_block), 64'h0);
        chk("R1 fe_unblock", 64'(fe_unblock), 64'h0);
        chk("R1 stage_active", 64'(stage_active), 64'h0);
        chk("R1 proto_err", 64'(proto_err), 64'h0);
        rst_n = 1'b1;
        model_step();
        run(300, 60, 0, 0, 0, 0);     // plain flow: R6 R7 R11
        run(3000, 95, 12, 35, 0, 0);  // stalls, skid fill, R14 corners
        run(1500, 80, 8, 40, 6, 0);   // squash traffic: R10 R3
        run(300, 70, 5, 0, 2, 1);     // clear without set: R13
        @(negedge clk);
        compare();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule